// File: doc/BRIEF.md
# Chained Two-Channel Circular Result Mover

This block moves conversion results out of two banks of result registers and into a small local memory. It runs two transfer channels back to back. One hardware request starts the first channel. That channel makes eight 16-bit moves. Its completion then starts the second channel directly, with no further request. When the second channel has made its own eight moves, the block raises an interrupt. The interrupt stays up until software clears it.

Every address register wraps inside a power-of-two window. The block adds the step to an address, but only the low bits of the address take the new value. The bits above the window length keep their value. The source addresses select result registers that are spaced 4 bytes apart. The destination addresses select halfwords in the local memory. If the second channel's destination start is placed 2 bytes above the first, the two result sets land interleaved, one halfword from each channel in every 4-byte slot.

An address load strobe sets the four start addresses while the block is idle. The bench reads the memory back through a combinational read port.

Top module: `dma_chain_pair`

## Requirements
- R1: After reset, `irq` and `busy` are 0 and every location of the destination memory reads 0.
- R2: The source address of a channel advances by 4 after each move. Only bits [4:0] change and bits [15:5] stay as loaded, so the address wraps inside a 32-byte window. The moved value is result register k of that channel's bank (`srcBankN[16k+15:16k]`), where k is source address bits [4:2].
- R3: The destination address of a channel advances by 4 after each move. Only bits [4:0] change and the higher bits stay fixed. Each move writes the halfword at memory index = destination address bits [5:1].
- R4: A pulse on `adcReq` while idle starts channel 0. Channel 0 makes eight moves, one per clock. Channel 1 then makes eight moves with no further request. `busy` is 1 from the edge that samples the request until the last move.
- R5: `irq` rises on the 16th rising edge after the edge that samples the request. That is the edge of channel 1's last move, and no earlier edge raises it.
- R6: `irq` holds at 1 until a clock edge sees `irqClr` high, which returns it to 0. If a new completion falls on the same edge, the completion wins.
- R7: Addresses are not reset between transactions. Each transaction continues from the wrapped addresses that the previous one left behind.
- R8: A request that arrives while the block is busy is remembered, once. The next transaction starts on the edge that completes the current one. Its own `irq` then rises 16 edges after the first.
- R9: A `cfgLoad` pulse while idle sets both channels' source and destination start addresses from the `cfg*` inputs.
- R10: With channel 1's destination start 2 bytes above channel 0's, the two channels' results interleave halfword by halfword in memory.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| adcReq | input | 1 | Hardware start request (end of conversion scan) |
| irqClr | input | 1 | Clears the completion interrupt |
| cfgLoad | input | 1 | Loads the four start addresses while idle |
| cfgSrcAddr0 | input | 16 | Channel 0 source start address |
| cfgSrcAddr1 | input | 16 | Channel 1 source start address |
| cfgDstAddr0 | input | 16 | Channel 0 destination start address |
| cfgDstAddr1 | input | 16 | Channel 1 destination start address |
| srcBank0 | input | 128 | Eight 16-bit result registers read by channel 0 |
| srcBank1 | input | 128 | Eight 16-bit result registers read by channel 1 |
| rdIdx | input | 5 | Halfword index of the memory read port |
| rdData | output | 16 | Memory contents at `rdIdx` |
| irq | output | 1 | Completion interrupt of the chained pair |
| busy | output | 1 | A transaction is in progress |

## Verification
A corrupted upper address bit shows at the ports as soon as the affected channel's first move completes. The write then lands outside the expected 32-byte window, so a halfword that should stay zero becomes nonzero, and the readback of the whole memory exposes it. A wrong move count or a broken chain shifts the `irq` edge away from the 16th cycle. A lost pending request removes the second interrupt. Both show within one transaction, because the bench checks the interrupt on exact edges. A wrong start offset or register index puts the right values in rotated positions. The bench sweeps all eight start offsets of the window to catch this.

// File: rtl/dma_chain_pkg.sv
package dma_chain_pkg;

  // Strobes from the sequencer to the address/data path
  typedef struct packed {
    logic move;  // perform one move this cycle
    logic chan;  // which channel moves (0 or 1)
    logic load;  // take start addresses from the configuration inputs
  } dmaStrb_t;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN0 = 2'd1,
    ST_RUN1 = 2'd2
  } seqState_t;

endpackage

// File: rtl/dma_chain_datapath.sv
module dma_chain_datapath
  import dma_chain_pkg::*;
#(
  parameter int ADDR_W     = 16,
  parameter int DATA_W     = 16,
  parameter int MOVES      = 8,
  parameter int SRC_STEP   = 4,
  parameter int DST_STEP   = 4,
  parameter int SRC_LEN    = 5,
  parameter int DST_LEN    = 5,
  parameter int DMEM_IDX_W = 5
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  dmaStrb_t                  strb,
  input  logic [ADDR_W-1:0]         cfgSrcAddr0,
  input  logic [ADDR_W-1:0]         cfgSrcAddr1,
  input  logic [ADDR_W-1:0]         cfgDstAddr0,
  input  logic [ADDR_W-1:0]         cfgDstAddr1,
  input  logic [MOVES*DATA_W-1:0]   srcBank0,
  input  logic [MOVES*DATA_W-1:0]   srcBank1,
  input  logic [DMEM_IDX_W-1:0]     rdIdx,
  output logic [DATA_W-1:0]         rdData
);

  localparam int SIDX_W     = $clog2(MOVES);
  localparam int DMEM_DEPTH = 1 << DMEM_IDX_W;
  localparam logic [ADDR_W-1:0] SRC_MASK = ADDR_W'((1 << SRC_LEN) - 1);
  localparam logic [ADDR_W-1:0] DST_MASK = ADDR_W'((1 << DST_LEN) - 1);
  localparam logic [ADDR_W-1:0] SRC_INC  = ADDR_W'(SRC_STEP);
  localparam logic [ADDR_W-1:0] DST_INC  = ADDR_W'(DST_STEP);

  logic [ADDR_W-1:0] srcAddr [2];
  logic [ADDR_W-1:0] dstAddr [2];
  logic [ADDR_W-1:0] cfgSrc  [2];
  logic [ADDR_W-1:0] cfgDst  [2];
  logic [DATA_W-1:0] dmem    [DMEM_DEPTH];

  assign cfgSrc[0] = cfgSrcAddr0;
  assign cfgSrc[1] = cfgSrcAddr1;
  assign cfgDst[0] = cfgDstAddr0;
  assign cfgDst[1] = cfgDstAddr1;

  // Add the step but keep every bit above the window length
  function automatic logic [ADDR_W-1:0] circNext(input logic [ADDR_W-1:0] a,
                                                 input logic [ADDR_W-1:0] inc,
                                                 input logic [ADDR_W-1:0] mask);
    return (a & ~mask) | ((a + inc) & mask);
  endfunction

  for (genvar g = 0; g < 2; g++) begin : gChan
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        srcAddr[g] <= '0;
        dstAddr[g] <= '0;
      end else if (strb.load) begin
        srcAddr[g] <= cfgSrc[g];
        dstAddr[g] <= cfgDst[g];
      end else if (strb.move && (strb.chan == 1'(g))) begin
        srcAddr[g] <= circNext(srcAddr[g], SRC_INC, SRC_MASK);
        dstAddr[g] <= circNext(dstAddr[g], DST_INC, DST_MASK);
      end
    end

    AST_SRC_UPPER_FROZEN: assert property (@(posedge clk) disable iff (!rstN)
      (strb.move && !strb.load && strb.chan == 1'(g)) |=>
        ((srcAddr[g] & ~SRC_MASK) == ($past(srcAddr[g]) & ~SRC_MASK))); // R2
    AST_DST_UPPER_FROZEN: assert property (@(posedge clk) disable iff (!rstN)
      (strb.move && !strb.load && strb.chan == 1'(g)) |=>
        ((dstAddr[g] & ~DST_MASK) == ($past(dstAddr[g]) & ~DST_MASK))); // R3
    AST_ADDR_HELD_IDLE: assert property (@(posedge clk) disable iff (!rstN)
      (!strb.move && !strb.load) |=> ($stable(srcAddr[g]) && $stable(dstAddr[g]))); // R7
  end

  // Data selection for the active channel
  logic [SIDX_W-1:0]     srcIdx;
  logic [DMEM_IDX_W-1:0] dstIdx;
  logic [DATA_W-1:0]     moveVal;

  always_comb begin
    srcIdx  = srcAddr[strb.chan][2 +: SIDX_W];
    dstIdx  = dstAddr[strb.chan][1 +: DMEM_IDX_W];
    moveVal = strb.chan ? srcBank1[srcIdx*DATA_W +: DATA_W]
                        : srcBank0[srcIdx*DATA_W +: DATA_W];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < DMEM_DEPTH; i++) dmem[i] <= '0;
    end else if (strb.move) begin
      dmem[dstIdx] <= moveVal;
    end
  end

  assign rdData = dmem[rdIdx];

endmodule

// File: rtl/dma_chain_ctrl.sv
module dma_chain_ctrl
  import dma_chain_pkg::*;
#(
  parameter int MOVES = 8
) (
  input  logic     clk,
  input  logic     rstN,
  input  logic     adcReq,
  input  logic     irqClr,
  input  logic     cfgLoad,
  output dmaStrb_t strb,
  output logic     irq,
  output logic     busy
);

  localparam int CNT_W = $clog2(MOVES);

  seqState_t        state;
  logic [CNT_W-1:0] moveCnt;
  logic             pending;
  logic             lastMove;

  assign lastMove = (moveCnt == CNT_W'(MOVES - 1));
  assign busy     = (state != ST_IDLE);

  always_comb begin
    strb.move = (state != ST_IDLE);
    strb.chan = (state == ST_RUN1);
    strb.load = cfgLoad && (state == ST_IDLE);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      moveCnt <= '0;
      pending <= 1'b0;
    end else if (state == ST_IDLE) begin
      moveCnt <= '0;
      pending <= 1'b0;
      if (adcReq || pending) state <= ST_RUN0;
    end else begin
      moveCnt <= lastMove ? '0 : moveCnt + 1'b1;
      if (state == ST_RUN1 && lastMove) begin
        state   <= (pending || adcReq) ? ST_RUN0 : ST_IDLE;
        pending <= 1'b0;
      end else begin
        if (adcReq) pending <= 1'b1;
        if (lastMove) state <= ST_RUN1;  // internal request to channel 1
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                            irq <= 1'b0;
    else if (state == ST_RUN1 && lastMove) irq <= 1'b1;
    else if (irqClr)                       irq <= 1'b0;
  end

  AST_CHAIN_TO_CH1: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_RUN0 && lastMove) |=> (state == ST_RUN1)); // R4
  AST_IRQ_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    (irq && !irqClr) |=> irq); // R6
  AST_IRQ_AFTER_CH1: assert property (@(posedge clk) disable iff (!rstN)
    $rose(irq) |-> ($past(state) == ST_RUN1)); // R5
  AST_REQ_REMEMBERED: assert property (@(posedge clk) disable iff (!rstN)
    (adcReq && busy && !(state == ST_RUN1 && lastMove)) |=> (pending && busy)); // R8

endmodule

// File: rtl/dma_chain_pair.sv
module dma_chain_pair
  import dma_chain_pkg::*;
#(
  parameter int ADDR_W     = 16,
  parameter int DATA_W     = 16,
  parameter int MOVES      = 8,
  parameter int SRC_STEP   = 4,
  parameter int DST_STEP   = 4,
  parameter int SRC_LEN    = 5,
  parameter int DST_LEN    = 5,
  parameter int DMEM_IDX_W = 5
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    adcReq,
  input  logic                    irqClr,
  input  logic                    cfgLoad,
  input  logic [ADDR_W-1:0]       cfgSrcAddr0,
  input  logic [ADDR_W-1:0]       cfgSrcAddr1,
  input  logic [ADDR_W-1:0]       cfgDstAddr0,
  input  logic [ADDR_W-1:0]       cfgDstAddr1,
  input  logic [MOVES*DATA_W-1:0] srcBank0,
  input  logic [MOVES*DATA_W-1:0] srcBank1,
  input  logic [DMEM_IDX_W-1:0]   rdIdx,
  output logic [DATA_W-1:0]       rdData,
  output logic                    irq,
  output logic                    busy
);

  dmaStrb_t strb;

  dma_chain_ctrl #(.MOVES(MOVES)) u_ctrl (
    .clk(clk), .rstN(rstN), .adcReq(adcReq), .irqClr(irqClr),
    .cfgLoad(cfgLoad), .strb(strb), .irq(irq), .busy(busy)
  );

  dma_chain_datapath #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .MOVES(MOVES),
    .SRC_STEP(SRC_STEP), .DST_STEP(DST_STEP),
    .SRC_LEN(SRC_LEN), .DST_LEN(DST_LEN), .DMEM_IDX_W(DMEM_IDX_W)
  ) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb),
    .cfgSrcAddr0(cfgSrcAddr0), .cfgSrcAddr1(cfgSrcAddr1),
    .cfgDstAddr0(cfgDstAddr0), .cfgDstAddr1(cfgDstAddr1),
    .srcBank0(srcBank0), .srcBank1(srcBank1),
    .rdIdx(rdIdx), .rdData(rdData)
  );

endmodule

// File: tb/dma_chain_pair_tb.sv
module dma_chain_pair_tb;

  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic         adcReq = 1'b0, irqClr = 1'b0, cfgLoad = 1'b0;
  logic [15:0]  cfgSrcAddr0 = '0, cfgSrcAddr1 = '0, cfgDstAddr0 = '0, cfgDstAddr1 = '0;
  logic [127:0] srcBank0 = '0, srcBank1 = '0;
  logic [4:0]   rdIdx = '0;
  logic [15:0]  rdData;
  logic         irq, busy;

  int errors = 0;
  int checks = 0;
  bit done = 0;

  logic [15:0] expMem [32];
  logic [15:0] mSrc [2];
  logic [15:0] mDst [2];

  always #2 clk = ~clk;  // 250 MHz

  dma_chain_pair u_dut (
    .clk(clk), .rstN(rstN), .adcReq(adcReq), .irqClr(irqClr), .cfgLoad(cfgLoad),
    .cfgSrcAddr0(cfgSrcAddr0), .cfgSrcAddr1(cfgSrcAddr1),
    .cfgDstAddr0(cfgDstAddr0), .cfgDstAddr1(cfgDstAddr1),
    .srcBank0(srcBank0), .srcBank1(srcBank1),
    .rdIdx(rdIdx), .rdData(rdData), .irq(irq), .busy(busy)
  );

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Window of 32 bytes: bits [4:0] move, the rest stay
  function automatic logic [15:0] wrapAdd(input logic [15:0] a);
    return {a[15:5], 5'(a[4:0] + 5'd4)};
  endfunction

  // Expected effect of one chained transaction on the model memory
  task automatic modelTxn();
    for (int ch = 0; ch < 2; ch++) begin
      for (int m = 0; m < 8; m++) begin
        logic [2:0] k;
        k = mSrc[ch][4:2];
        expMem[mDst[ch][5:1]] = (ch == 0) ? srcBank0[k*16 +: 16] : srcBank1[k*16 +: 16];
        mSrc[ch] = wrapAdd(mSrc[ch]);
        mDst[ch] = wrapAdd(mDst[ch]);
      end
    end
  endtask

  task automatic checkMem(input string req);
    for (int i = 0; i < 32; i++) begin
      rdIdx = 5'(i);
      #0.1;
      check(req, rdData, expMem[i]);
    end
  endtask

  task automatic fillBanks(input int t);
    for (int k = 0; k < 8; k++) begin
      srcBank0[k*16 +: 16] = 16'((t + 1) * 16'h1111 ^ (k * 37) ^ 16'h0100);
      srcBank1[k*16 +: 16] = 16'((t + 3) * 16'h0707 ^ (k * 91) ^ 16'h8000);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 32; i++) expMem[i] = '0;
    repeat (3) @(posedge clk);
    @(negedge clk) rstN = 1'b1;
    // R1 reset state
    check("R1 irq", {15'd0, irq}, 16'd0);
    check("R1 busy", {15'd0, busy}, 16'd0);
    checkMem("R1 memory cleared");

    // Sweep every start offset inside the windows
    for (int s = 0; s < 8; s++) begin
      @(negedge clk);
      cfgSrcAddr0 = 16'h0180 + 16'(4 * s);
      cfgSrcAddr1 = 16'h0180 + 16'(4 * ((s + 3) % 8));
      cfgDstAddr0 = 16'h0020 + 16'(4 * s);
      cfgDstAddr1 = 16'h0020 + 16'(4 * s) + 16'd2;  // R10 interleave
      cfgLoad = 1'b1;
      @(posedge clk);
      @(negedge clk) cfgLoad = 1'b0;
      mSrc[0] = cfgSrcAddr0; mSrc[1] = cfgSrcAddr1;
      mDst[0] = cfgDstAddr0; mDst[1] = cfgDstAddr1;
      fillBanks(s);
      modelTxn();
      adcReq = 1'b1;
      @(posedge clk);                       // request sampled
      @(negedge clk) adcReq = 1'b0;
      check("R4 busy after request", {15'd0, busy}, 16'd1);
      repeat (15) @(posedge clk);
      @(negedge clk);
      check("R5 irq not before last move", {15'd0, irq}, 16'd0);
      @(posedge clk);
      @(negedge clk);
      check("R5 irq on 16th edge", {15'd0, irq}, 16'd1);
      check("R4 idle after channel 1", {15'd0, busy}, 16'd0);
      repeat (3) @(posedge clk);
      @(negedge clk);
      check("R6 irq held", {15'd0, irq}, 16'd1);
      irqClr = 1'b1;
      @(posedge clk);
      @(negedge clk) irqClr = 1'b0;
      check("R6 irq cleared", {15'd0, irq}, 16'd0);
      checkMem("R2 R3 R9 R10 memory after transaction");
    end

    // R7 and R8: no reload, second request arrives while busy
    @(negedge clk);
    fillBanks(20);
    modelTxn();
    modelTxn();
    adcReq = 1'b1;
    @(posedge clk);
    @(negedge clk) adcReq = 1'b0;
    repeat (4) @(posedge clk);
    @(negedge clk) adcReq = 1'b1;
    @(posedge clk);
    @(negedge clk) adcReq = 1'b0;
    repeat (10) @(posedge clk);
    @(negedge clk);
    check("R5 first irq not early", {15'd0, irq}, 16'd0);
    @(posedge clk);
    @(negedge clk);
    check("R8 first irq", {15'd0, irq}, 16'd1);
    check("R8 still busy with pending", {15'd0, busy}, 16'd1);
    irqClr = 1'b1;
    @(posedge clk);
    @(negedge clk) irqClr = 1'b0;
    check("R6 clear between transactions", {15'd0, irq}, 16'd0);
    repeat (14) @(posedge clk);
    @(negedge clk);
    check("R8 second irq not early", {15'd0, irq}, 16'd0);
    check("R8 busy in second transaction", {15'd0, busy}, 16'd1);
    @(posedge clk);
    @(negedge clk);
    check("R8 second irq", {15'd0, irq}, 16'd1);
    check("R8 idle after second", {15'd0, busy}, 16'd0);
    irqClr = 1'b1;
    @(posedge clk);
    @(negedge clk) irqClr = 1'b0;
    checkMem("R7 continued addresses");

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule